// File: doc/BRIEF.md
# Prescaled Modulus Timer

This block is a 16-bit up-counter that advances on ticks from a power-of-two divider of the bus clock. A control byte sets three things: the divide ratio, whether the counter is cleared when it reaches a compare value, and whether an overflow raises an interrupt request. When clearing on compare is off, the counter runs freely. It sets a sticky overflow flag each time it rolls over from its top value to zero. When clearing on compare is on, the counter acts as a modulus counter whose length is set by the compare register.

Software reaches the block through a small synchronous byte-wide register port. The port writes on a clock edge and reads back combinationally. The offsets are: 0 control, 1 flags, 2 and 3 the low and high bytes of the compare value, and 4 and 5 the low and high bytes of the counter. The counter bytes are read-only. Any other offset reads as zero. Three outputs go to the rest of the chip: the overflow flag, the gated interrupt request, and a one-cycle pulse for each compare match.

Top module: `prescaled_mod_timer`

## Requirements
- R1: After reset the control byte and the flag byte read 0. The overflow flag, the interrupt request and the compare pulse are 0. The counter advances by one on every bus clock (divide-by-1, no clearing on compare).
- R2: Control byte layout: bit 7 is the overflow interrupt enable, bit 3 is the clear-on-compare enable, and bits 2:0 are the divide select. Bits 6:4 and 5:4 read as 0 whatever was written to them.
- R3: Divide select code k (0 to 7) makes the counter advance once every 2^k bus clocks.
- R4: Any write to the control byte restarts the divider. The counter does not advance in the write cycle. Its first advance afterwards lands exactly 2^k bus clocks after the write edge.
- R5: With clearing on compare off, a rollover from 0xFFFF to 0x0000 sets the overflow flag in that same clock edge.
- R6: Writing a 1 to bit 0 of the flag byte (offset 1) clears the overflow flag. Writing a 0 there leaves it unchanged. A rollover in the same cycle wins over the clear.
- R7: The interrupt request is high exactly when the overflow flag and control bit 7 are both 1.
- R8: The compare pulse is high for one bus clock in the cycle after a divider tick moves the counter onto the compare value. It is never high for two cycles in a row while the compare value is non-zero.
- R9: With clearing on compare on and a non-zero compare value N, the counter returns to 0x0000 one bus clock after the compare pulse, without waiting for a tick. This clear also restarts the divider, so the compare pulses repeat every N*2^k+1 bus clocks.
- R10: With clearing on compare on and a compare value of 0x0000, the counter reads 0x0000 on every cycle.
- R11: With clearing on compare on and a compare value of 0xFFFF, the counter returns to 0x0000 after reaching 0xFFFF and the overflow flag stays 0.
- R12: Offsets 2 and 3 read back the compare low and high bytes as written. Offsets 4 and 5 read the current counter bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte offset |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Combinational register read data |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| cmp_pulse | output | 1 | One-cycle compare match pulse |

## Verification
The counter's rate is measured over windows sized to the divide ratio at select codes 0, 3 and 7, so that a ratio off by one power of two shows up. It is also sampled cycle by cycle just after a control write, which separates a divider that restarts from one that keeps its old phase. The modulus mode is run with compare values 5 and 3 at ratios 1 and 4. A queue of expected pulse spacings (6 and 13 cycles) then distinguishes a clear that waits for the next tick from one that happens on the next bus clock. The compare values 0x0000 and 0xFFFF and a free-running rollover are each run to completion. Together they show the held-at-zero counter, the suppressed flag at the top value, and the exact edge on which the flag sets.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_FLAGS  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 3'd5;

  // control byte bit positions
  localparam int CTRL_IE_BIT  = 7;
  localparam int CTRL_CLR_BIT = 3;
  localparam int FLAG_OVF_BIT = 0;

  typedef struct packed {
    logic       ovf_ie;
    logic       clr_on_cmp;
    logic [2:0] div_sel;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W:0]   one_shift;
  logic [DIV_W-1:0] mask;

  always_comb begin
    one_shift = (DIV_W+1)'(1) << div_sel;
    mask      = DIV_W'(one_shift - (DIV_W+1)'(1));
    tick      = ((div_q & mask) == mask) && !restart;
    div_d     = restart ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R4: a restart leaves the divider phase at zero
  a_r4_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (div_q == '0));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr_on_cmp,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic             wrap,
  output logic             mod_clear
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             hit_q, hit_d;
  logic             hold_zero;

  always_comb begin
    cnt_inc   = cnt_q + CNT_W'(1);
    hold_zero = clr_on_cmp && (cmp_val == '0);
    cnt_d     = cnt_q;
    hit_d     = 1'b0;
    wrap      = 1'b0;
    mod_clear = 1'b0;
    if (hold_zero) begin
      cnt_d = '0;
      hit_d = tick;
    end else if (clr_on_cmp && hit_q) begin
      cnt_d     = '0;
      mod_clear = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_inc;
      hit_d = (cnt_inc == cmp_val);
      wrap  = (cnt_q == '1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  assign cnt = cnt_q;
  assign hit = hit_q;

  // R10: zero compare with clearing enabled pins the counter at zero
  a_r10_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> (cnt_q == '0));
  // R9: a match with clearing enabled zeroes the counter on the next clock
  a_r9_mod_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_cmp && hit_q && (cmp_val != '0)) |=> (cnt_q == '0));
  // R8: the match pulse lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !hold_zero && (cnt_q == cmp_val)) |=> !hit_q);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output tmr_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              ovf_flag,
  output logic              ctrl_wr
);
  localparam int HI_W = CNT_W - 8;

  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             flag_q, flag_d;
  logic             flag_clr, cmp_lo_wr, cmp_hi_wr;

  always_comb begin
    ctrl_wr   = wr_en && (addr == OFS_CTRL);
    cmp_lo_wr = wr_en && (addr == OFS_CMP_LO);
    cmp_hi_wr = wr_en && (addr == OFS_CMP_HI);
    flag_clr  = wr_en && (addr == OFS_FLAGS) && wdata[FLAG_OVF_BIT];

    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.ovf_ie     = wdata[CTRL_IE_BIT];
      ctrl_d.clr_on_cmp = wdata[CTRL_CLR_BIT];
      ctrl_d.div_sel    = wdata[2:0];
    end

    cmp_d = cmp_q;
    if (cmp_lo_wr) cmp_d[7:0]       = wdata;
    if (cmp_hi_wr) cmp_d[CNT_W-1:8] = wdata[HI_W-1:0];

    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr)                ctrl_q <= ctrl_d;
      if (cmp_lo_wr || cmp_hi_wr) cmp_q  <= cmp_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      OFS_CTRL: begin
        rdata[CTRL_IE_BIT]  = ctrl_q.ovf_ie;
        rdata[CTRL_CLR_BIT] = ctrl_q.clr_on_cmp;
        rdata[2:0]          = ctrl_q.div_sel;
      end
      OFS_FLAGS:  rdata[FLAG_OVF_BIT] = flag_q;
      OFS_CMP_LO: rdata = cmp_q[7:0];
      OFS_CMP_HI: rdata = 8'(cmp_q[CNT_W-1:8]);
      OFS_CNT_LO: rdata = cnt[7:0];
      OFS_CNT_HI: rdata = 8'(cnt[CNT_W-1:8]);
      default:    rdata = 8'h00;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign cmp_val  = cmp_q;
  assign ovf_flag = flag_q;

  // R5: a rollover sets the flag on the same edge
  a_r5_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q);
  // R6: without a one written to the clear bit the flag stays set
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/prescaled_mod_timer.sv
module prescaled_mod_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ovf_flag,
  output logic              irq,
  output logic              cmp_pulse
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] cmp_val, cnt;
  logic             ctrl_wr, tick, wrap, mod_clear, restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign restart = ctrl_wr || mod_clear;

  tmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt(cnt), .wrap(wrap), .ctrl(ctrl), .cmp_val(cmp_val),
    .ovf_flag(ovf_flag), .ctrl_wr(ctrl_wr)
  );

  tmr_prescaler #(.SEL_W(SEL_W)) presc_i (
    .clk(clk), .rst_n(rst_int_n), .restart(restart),
    .div_sel(ctrl.div_sel[SEL_W-1:0]), .tick(tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .clr_on_cmp(ctrl.clr_on_cmp),
    .cmp_val(cmp_val), .cnt(cnt), .hit(cmp_pulse), .wrap(wrap),
    .mod_clear(mod_clear)
  );

  assign irq = ovf_flag && ctrl.ovf_ie;
endmodule

// File: tb/prescaled_mod_timer_tb_top.sv
module prescaled_mod_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ovf_flag, irq, cmp_pulse;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;
  longint last_hit = 0;
  int gap_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prescaled_mod_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ovf_flag(ovf_flag), .irq(irq), .cmp_pulse(cmp_pulse)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // scoreboard monitor: pops expected spacing between compare pulses
  always @(negedge clk) begin
    if (rst_n && cmp_pulse) begin
      if (gap_q.size() > 0) begin
        int g;
        g = gap_q.pop_front();
        if (g != 0) chk((cyc - last_hit) == g, "R9 pulse spacing", cyc - last_hit, g);
      end
      last_hit = cyc;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, v0, v1;
    int n;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(ovf_flag == 0, "R1 ovf_flag", ovf_flag, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rd(3'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(3'd1, v); chk(v == 8'h00, "R1 flags", v, 0);
    rd(3'd4, v0); rd(3'd4, v1);
    chk(8'(v1 - v0) == 1, "R1 div1 step", 8'(v1 - v0), 1);

    // R2 layout and reserved bits
    wr(3'd0, 8'hFF); rd(3'd0, v); chk(v == 8'h8F, "R2 ctrl all ones", v, 8'h8F);
    wr(3'd0, 8'h70); rd(3'd0, v); chk(v == 8'h00, "R2 reserved only", v, 0);

    // R12 compare readback
    wr(3'd2, 8'hA5); wr(3'd3, 8'h3C);
    rd(3'd2, v); chk(v == 8'hA5, "R12 cmp lo", v, 8'hA5);
    rd(3'd3, v); chk(v == 8'h3C, "R12 cmp hi", v, 8'h3C);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R3 rates
    for (int k = 0; k < 8; k += (k == 0) ? 3 : 4) begin
      wr(3'd0, 8'(k));
      rd(3'd4, v0);
      repeat ((8 << k) - 1) @(negedge clk);
      rd(3'd4, v1);
      chk(8'(v1 - v0) == 8, $sformatf("R3 sel %0d", k), 8'(v1 - v0), 8);
    end

    // R4 divider restart on control write
    wr(3'd0, 8'h02);
    addr = 3'd4; #1 v0 = rdata;
    repeat (3) @(negedge clk);
    #1 chk(rdata == v0, "R4 no early tick", rdata, v0);
    @(negedge clk);
    #1 chk(rdata == 8'(v0 + 1), "R4 first tick", rdata, 8'(v0 + 1));

    // R10 zero hold, then modulus 5 at ratio 1
    wr(3'd0, 8'h08);
    for (int i = 0; i < 3; i++) begin
      rd(3'd4, v); chk(v == 0, "R10 held lo", v, 0);
    end
    wr(3'd2, 8'd5);
    repeat (2) @(negedge clk);
    gap_q = '{0, 6, 6, 6};
    while (gap_q.size() > 0) @(negedge clk);

    // modulus 3 at ratio 4
    wr(3'd2, 8'd0);
    wr(3'd0, 8'h0A);
    wr(3'd2, 8'd3);
    repeat (2) @(negedge clk);
    gap_q = '{0, 13, 13, 13};
    while (gap_q.size() > 0) @(negedge clk);

    // R11 top compare value
    wr(3'd2, 8'd0);
    wr(3'd0, 8'h08);
    wr(3'd3, 8'hFF);
    wr(3'd2, 8'hFF);
    repeat (4) @(negedge clk);
    addr = 3'd4;
    n = 0;
    while (!cmp_pulse && n < 70000) begin @(negedge clk); n++; end
    @(negedge clk);
    #1 chk(rdata == 0, "R11 cleared after top", rdata, 0);
    chk(cmp_pulse == 0, "R8 one cycle pulse", cmp_pulse, 0);
    repeat (3) @(negedge clk);
    chk(ovf_flag == 0, "R11 no flag", ovf_flag, 0);
    rd(3'd1, v); chk(v == 0, "R11 flag byte", v, 0);

    // R5 free-running rollover timing
    wr(3'd2, 8'd0); wr(3'd3, 8'd0);
    wr(3'd0, 8'h08);
    wr(3'd0, 8'h80);
    chk(irq == 0, "R7 no flag no irq", irq, 0);
    n = 0;
    while (!ovf_flag && n < 70000) begin @(negedge clk); n++; end
    chk(n == 65536, "R5 rollover edge", n, 65536);
    chk(irq == 1, "R7 irq on", irq, 1);
    rd(3'd1, v); chk(v == 8'h01, "R5 flag byte", v, 1);
    wr(3'd0, 8'h00);
    chk(irq == 0, "R7 masked", irq, 0);
    chk(ovf_flag == 1, "R6 flag kept after mask", ovf_flag, 1);
    wr(3'd1, 8'hFE);
    chk(ovf_flag == 1, "R6 zero write ignored", ovf_flag, 1);
    wr(3'd1, 8'h01);
    chk(ovf_flag == 0, "R6 cleared", ovf_flag, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule